// File: doc/BRIEF.md
# Accelerometer Motion Event Detector

This block watches a stream of three signed acceleration samples (X, Y, Z) and raises a motion interrupt when a chosen pattern appears. A sample is taken only on a cycle where the sample-valid strobe is high. For each sample the block measures each axis against a programmable threshold. It then applies one of four event rules and, where the rule calls for it, a duration qualifier counted in samples. The result is a 7-bit status word and an interrupt line. The status word can either follow the live condition or hold its flags until software reads it.

The four rules are as follows. Wake-up fires when any enabled axis condition is true. Free-fall fires when every enabled low condition is true at once. Orientation position fires while the dominant direction of the device lies in the enabled set. Orientation movement fires on the sample where the dominant direction changes into the enabled set. The orientation rules can consider all six directions or only the four directions in the X/Y plane.

Top module: `motion_event_detector`

## Requirements
- R1: While reset is asserted, and after it is released until the first sample, `stat` is 0 and `irq` is low.
- R2: An axis is high when (|sample| >> 8) > `cfg_thr` and low otherwise. Status bits 5..0 are ZH, ZL, YH, YL, XH, XL. Bit 6 is the event flag. Flag bits are nonzero only together with bit 6.
- R3: When `cfg_mode` = 00 (wake-up), an event occurs when the axis flags ANDed with `cfg_en` are nonzero. Those ANDed flags are reported.
- R4: When `cfg_mode` = 10 (free-fall), an event occurs when at least one low enable (bits 4, 2, 0 of `cfg_en`) is set and all enabled lows are true. Only low flags are reported.
- R5: The dominant direction is the axis of largest magnitude. Ties favour X, then Y, then Z. The dominant axis must itself be high, otherwise there is no direction. A positive sample selects the H bit of that axis and a negative sample selects the L bit.
- R6: When `cfg_mode` = 11 (position), an event occurs while the dominant direction ANDed with `cfg_en` is nonzero. That single bit is reported.
- R7: When `cfg_mode` = 01 (movement), an event occurs on a sample whose enabled dominant direction is nonzero and differs from the dominant direction of the previous sample, whatever mode that sample was taken in. The duration setting is not applied in this mode.
- R8: When `cfg_four_dir` = 1, Z takes no part in the dominant-direction choice.
- R9: In modes 00, 10 and 11, an event is reported only once its condition has held on `cfg_dur`+1 consecutive samples. A sample that fails the condition restarts the count.
- R10: With `cfg_latch` = 0, `stat` changes only on samples, and `stat_rd` has no effect.
- R11: With `cfg_latch` = 1, each sample ORs its result into the held status. A `stat_rd` pulse without a sample clears it. A read in the same cycle as a sample leaves exactly that sample's result.
- R12: `irq` always equals bit 6 of `stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New sample strobe |
| smp_x | input | 16 | Signed X sample |
| smp_y | input | 16 | Signed Y sample |
| smp_z | input | 16 | Signed Z sample |
| cfg_mode | input | 2 | Event rule select |
| cfg_en | input | 6 | Axis condition enables, ZH..XL |
| cfg_thr | input | 7 | Threshold, 256 sample LSBs per step |
| cfg_dur | input | 7 | Extra consecutive samples required |
| cfg_latch | input | 1 | Hold status until read |
| cfg_four_dir | input | 1 | Exclude Z from orientation |
| stat_rd | input | 1 | Status read strobe |
| irq | output | 1 | Interrupt |
| stat | output | 7 | Event flag and axis flags |

## Verification
A corrupted duration count or previous-direction register does not show up at once. It shows only on the first later sample whose condition depends on it, as a missing event, a premature event or a missing movement edge. A bad held status shows up on the next cycle after a read, or after a quiet sample in latched mode. The bench therefore compares `stat` and `irq` against a reference model on every cycle, across random mode switches, and it forces these sequences with directed stretches that run through a count, break it and restart it.

// File: rtl/motion_event_detector.sv
module motion_event_detector #(
  parameter int SW = 16,
  parameter int TW = 7,
  parameter int DW = 7,
  parameter int SH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_x,
  input  logic signed [SW-1:0] smp_y,
  input  logic signed [SW-1:0] smp_z,
  input  logic [1:0]           cfg_mode,
  input  logic [5:0]           cfg_en,
  input  logic [TW-1:0]        cfg_thr,
  input  logic [DW-1:0]        cfg_dur,
  input  logic                 cfg_latch,
  input  logic                 cfg_four_dir,
  input  logic                 stat_rd,
  output logic                 irq,
  output logic [6:0]           stat
);
  localparam int MW = SW + 1;
  localparam int QW = MW - SH;

  logic [MW-1:0] mx, my, mz, bm;
  logic          hx, hy, hz, dom_hi, dom_neg;
  logic [1:0]    sel;
  logic [5:0]    hl, dir, prev_dir, flags, ffmask;
  logic          cond, fire;
  logic [DW-1:0] cnt;
  logic [6:0]    new_st, live, held;

  assign mx = smp_x[SW-1] ? (~{1'b1, smp_x} + 1'b1) : {1'b0, smp_x};
  assign my = smp_y[SW-1] ? (~{1'b1, smp_y} + 1'b1) : {1'b0, smp_y};
  assign mz = smp_z[SW-1] ? (~{1'b1, smp_z} + 1'b1) : {1'b0, smp_z};

  assign hx = mx[MW-1:SH] > QW'(cfg_thr);
  assign hy = my[MW-1:SH] > QW'(cfg_thr);
  assign hz = mz[MW-1:SH] > QW'(cfg_thr);
  assign hl = {hz, ~hz, hy, ~hy, hx, ~hx};

  always_comb begin
    sel = 2'd0;
    bm  = mx;
    dom_neg = smp_x[SW-1];
    if (my > bm) begin
      sel = 2'd1; bm = my; dom_neg = smp_y[SW-1];
    end
    if (!cfg_four_dir && mz > bm) begin
      sel = 2'd2; bm = mz; dom_neg = smp_z[SW-1];
    end
  end

  assign dom_hi = bm[MW-1:SH] > QW'(cfg_thr);

  always_comb begin
    dir = '0;
    if (dom_hi) dir[2*sel +: 2] = dom_neg ? 2'b01 : 2'b10;
  end

  assign ffmask = cfg_en & 6'b010101;

  always_comb begin
    case (cfg_mode)
      2'b00: begin flags = hl & cfg_en;  cond = |flags; end
      2'b10: begin flags = hl & ffmask;  cond = (ffmask != '0) && (flags == ffmask); end
      2'b01: begin flags = dir & cfg_en; cond = (|flags) && (dir != prev_dir); end
      default: begin flags = dir & cfg_en; cond = |flags; end
    endcase
  end

  assign fire   = (cfg_mode == 2'b01) ? cond : (cond && cnt >= cfg_dur);
  assign new_st = fire ? {1'b1, flags} : 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      prev_dir <= '0;
      live     <= '0;
    end else if (smp_valid) begin
      cnt      <= cond ? ((cnt < cfg_dur) ? cnt + 1'b1 : cnt) : '0;
      prev_dir <= dir;
      live     <= new_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held <= '0;
    else if (!cfg_latch) held <= '0;
    else if (smp_valid)  held <= (stat_rd ? 7'd0 : held) | new_st;
    else if (stat_rd)    held <= '0;
  end

  assign stat = cfg_latch ? held : live;
  assign irq  = stat[6];
endmodule

module motion_event_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic [1:0] cfg_mode,
  input logic       cfg_latch,
  input logic       stat_rd,
  input logic       irq,
  input logic [6:0] stat
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (stat == 7'd0 && !irq)); // R1
  AST_FLAGS_NEED_EVENT: assert property (@(posedge clk) disable iff (!rst_n) (stat[5:0] != 6'd0) |-> stat[6]); // R2
  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !stat_rd) |=> ($stable(cfg_latch) -> $stable(stat))); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch && stat_rd && !smp_valid) |=> (cfg_latch -> stat == 7'd0)); // R11
  AST_FREEFALL_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_mode == 2'b10 && !cfg_latch) |=> (!cfg_latch -> (stat & 7'h2A) == 7'd0)); // R4
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_mode[0] && !cfg_latch) |=> (!cfg_latch -> $onehot0(stat[5:0]))); // R5
  AST_IRQ_IS_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> stat[6]); // R12
endmodule

bind motion_event_detector motion_event_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cfg_mode(cfg_mode),
  .cfg_latch(cfg_latch), .stat_rd(stat_rd), .irq(irq), .stat(stat)
);

// File: tb/motion_event_detector_tb.sv
`timescale 1ns/1ps
module motion_event_detector_tb;
  logic clk = 0, rst_n = 0, smp_valid = 0, cfg_latch = 0, cfg_four_dir = 0, stat_rd = 0;
  logic signed [15:0] smp_x = 0, smp_y = 0, smp_z = 0;
  logic [1:0] cfg_mode = 0;
  logic [5:0] cfg_en = 0;
  logic [6:0] cfg_thr = 0, cfg_dur = 0;
  logic irq;
  logic [6:0] stat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  motion_event_detector u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .cfg_mode(cfg_mode), .cfg_en(cfg_en), .cfg_thr(cfg_thr),
    .cfg_dur(cfg_dur), .cfg_latch(cfg_latch), .cfg_four_dir(cfg_four_dir),
    .stat_rd(stat_rd), .irq(irq), .stat(stat)
  );

  // reference model
  logic [6:0] m_cnt, m_live, m_lat;
  logic [5:0] m_prev;

  function automatic logic [16:0] f_mag(logic signed [15:0] s);
    return s[15] ? 17'(-$signed({s[15], s})) : {1'b0, s};
  endfunction

  task automatic model_eval(output logic [6:0] ns, output logic [5:0] d, output logic c);
    logic [16:0] ax, ay, az, b;
    logic neg;
    logic [5:0] hl, fl, lm;
    int s;
    ax = f_mag(smp_x); ay = f_mag(smp_y); az = f_mag(smp_z);
    hl = {(az >> 8) > cfg_thr, (az >> 8) <= cfg_thr, (ay >> 8) > cfg_thr,
          (ay >> 8) <= cfg_thr, (ax >> 8) > cfg_thr, (ax >> 8) <= cfg_thr};
    s = 0; b = ax; neg = smp_x[15];
    if (ay > b) begin s = 1; b = ay; neg = smp_y[15]; end
    if (!cfg_four_dir && az > b) begin s = 2; b = az; neg = smp_z[15]; end
    d = 0;
    if ((b >> 8) > cfg_thr) d[2*s +: 2] = neg ? 2'b01 : 2'b10;
    lm = cfg_en & 6'b010101;
    case (cfg_mode)
      2'b00: begin fl = hl & cfg_en; c = fl != 0; end
      2'b10: begin fl = hl & lm; c = (lm != 0) && (fl == lm); end
      2'b01: begin fl = d & cfg_en; c = (fl != 0) && (d != m_prev); end
      default: begin fl = d & cfg_en; c = fl != 0; end
    endcase
    if (cfg_mode == 2'b01) ns = c ? {1'b1, fl} : 0;
    else ns = (c && m_cnt >= cfg_dur) ? {1'b1, fl} : 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [6:0] ns; logic [5:0] d; logic c; logic [6:0] base;
    if (!rst_n) begin
      m_cnt = 0; m_live = 0; m_lat = 0; m_prev = 0;
    end else begin
      ns = 0;
      if (smp_valid) begin
        model_eval(ns, d, c);
        m_cnt = c ? ((m_cnt < cfg_dur) ? m_cnt + 1 : m_cnt) : 0;
        m_prev = d;
        m_live = ns;
      end
      base = stat_rd ? 7'd0 : m_lat;
      if (!cfg_latch) m_lat = 0;
      else if (smp_valid) m_lat = base | ns;
      else if (stat_rd) m_lat = 0;
    end
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: stat actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq();
    checks++;
    if (irq !== stat[6]) begin
      errors++;
      $display("FAIL R12: irq actual=%b expected=%b", irq, stat[6]);
    end
  endtask

  // one sample, then check on the following negedge
  task automatic samp(logic signed [15:0] x, y, z, string tag, logic [6:0] exp, logic rd = 0);
    smp_x = x; smp_y = y; smp_z = z; smp_valid = 1; stat_rd = rd;
    @(negedge clk);
    smp_valid = 0; stat_rd = 0;
    chk(tag, stat, exp);
  endtask

  task automatic setcfg(logic [1:0] m, logic [5:0] e, logic [6:0] t, logic [6:0] d, logic l, logic f);
    cfg_mode = m; cfg_en = e; cfg_thr = t; cfg_dur = d; cfg_latch = l; cfg_four_dir = f;
  endtask

  function automatic string rtag();
    if (cfg_latch) return "R11";
    case (cfg_mode)
      2'b00: return "R3";
      2'b01: return "R7";
      2'b10: return "R4";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1", stat, 0); chk_irq();
    rst_n = 1;
    @(negedge clk);
    chk("R1", stat, 0);

    // R2 / R3 classification and wake-up
    setcfg(2'b00, 6'h3F, 7'd4, 7'd0, 0, 0);
    samp(16'sh0500, 16'sh0400, -16'sh0500, "R2", 7'h66);
    chk_irq();
    samp(16'sh04FF, 16'sh0400, 16'sh0000, "R2", 7'h55);
    cfg_en = 6'h2A;
    samp(16'sh04FF, 16'sh0400, 16'sh0000, "R3", 7'h00);

    // R4 free-fall
    setcfg(2'b10, 6'h15, 7'd4, 7'd0, 0, 0);
    samp(16'sh0100, -16'sh0100, 16'sh0000, "R4", 7'h55);
    samp(16'sh0100, -16'sh0100, 16'sh0600, "R4", 7'h00);
    cfg_en = 6'h00;
    samp(16'sh0100, -16'sh0100, 16'sh0000, "R4", 7'h00);

    // R5 / R6 position
    setcfg(2'b11, 6'h3F, 7'd2, 7'd0, 0, 0);
    samp(16'sh0300, -16'sh0500, 16'sh0400, "R5", 7'h44);
    samp(16'sh0500, 16'sh0500, 16'sh0000, "R5", 7'h42);
    samp(16'sh0100, 16'sh0100, 16'sh0100, "R6", 7'h00);

    // R8 four-direction
    samp(16'sh0100, 16'sh0200, -16'sh0700, "R8", 7'h50);
    cfg_four_dir = 1;
    samp(16'sh0100, 16'sh0200, -16'sh0700, "R8", 7'h00);

    // R7 movement, duration ignored
    setcfg(2'b01, 6'h3F, 7'd2, 7'd5, 0, 0);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R7", 7'h42);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R7", 7'h00);
    samp(16'sh0100, -16'sh0800, 16'sh0000, "R7", 7'h44);

    // R9 duration
    setcfg(2'b00, 6'h02, 7'd2, 7'd2, 0, 0);
    samp(16'sh0000, 16'sh0000, 16'sh0000, "R9", 7'h00);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R9", 7'h00);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R9", 7'h00);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R9", 7'h42);
    samp(16'sh0000, 16'sh0000, 16'sh0000, "R9", 7'h00);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R9", 7'h00);

    // R10 non-latched hold, read ignored
    cfg_dur = 0;
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R10", 7'h42);
    smp_x = 0; stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk("R10", stat, 7'h42);

    // R11 latched
    cfg_latch = 1;
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R11", 7'h42);
    samp(16'sh0000, 16'sh0000, 16'sh0000, "R11", 7'h42);
    stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk("R11", stat, 7'h00);
    samp(16'sh0000, 16'sh0000, 16'sh0000, "R11", 7'h00);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R11", 7'h42);
    samp(16'sh0000, 16'sh0000, 16'sh0000, "R11", 7'h00, 1);
    samp(16'sh0400, 16'sh0000, 16'sh0000, "R11", 7'h42, 1);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0)
        setcfg(2'($urandom), 6'($urandom), 7'($urandom % 8), 7'($urandom % 4),
               1'($urandom % 4 == 0), 1'($urandom % 2));
      smp_valid = 1'($urandom % 2);
      stat_rd   = 1'($urandom % 8 == 0);
      smp_x = $signed(16'($urandom)) >>> ($urandom % 7);
      smp_y = $signed(16'($urandom)) >>> ($urandom % 7);
      smp_z = $signed(16'($urandom)) >>> ($urandom % 7);
      @(negedge clk);
      chk(rtag(), stat, cfg_latch ? m_lat : m_live);
      chk_irq();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule